// File: doc/BRIEF.md
# Serial Interrupt Bus Host

This block is the host end of a shared single-wire interrupt bus. All agents pull the wire down open-drain and a pull-up holds it high. The bus runs on the system bus clock. Each bus cycle has three parts. First comes a low Start pulse. Next comes a run of three-clock data frames, in which every peripheral may pull the wire low in the first clock of the frame it owns. Last comes a Stop pulse. The host samples the wire in the first clock of every frame and keeps the result in a 16-bit vector. A low sample means the interrupt or data line behind that frame is asserted.

The bus has two modes. In continuous mode the host opens a new cycle right after every Stop pulse, so peripherals never start one. In quiet mode the host leaves the wire released until a peripheral pulls it low. The host treats that low clock as the first clock of a Start pulse and extends the pulse itself. The width of the Stop pulse tells every agent which mode the next cycle uses. The host reads its mode request only when a Stop pulse begins.

Top module: `sirq_host`

## Requirements
- R1: During reset and after it, `irq_vec` reads all ones and the host releases the wire. The bus comes out of reset in continuous mode, so the host opens the first Start pulse without any peripheral activity.
- R2: A Start pulse that the host opens stays low for L+1 clocks, where L is the effective length setting (3 to 7). It is therefore 4 to 8 clocks wide.
- R3: In quiet mode, a low level on the released wire is taken as a Start pulse begun by a peripheral. That clock counts as the first low clock, and the host drives the wire low for L further clocks, for L+1 in total.
- R4: After every Start low pulse, the host drives the wire high for exactly one clock. It then releases the wire for the 48 clocks of the data frames.
- R5: The high clock is clock 1 after the rising edge. Frame n (1 to 16) is sampled on clock 3n-1 and lands in `irq_vec` bit n-1: bit 0 is the unused frame, bit 1 is IRQ1, bit 2 is IRQ2 or SMI, and bit k is IRQk. A low sample stores 0 and a high sample stores 1.
- R6: A low level during the second or third clock of a frame has no effect on `irq_vec`.
- R7: The Stop pulse is driven low for 2 clocks when quiet mode is selected and for 3 clocks when continuous mode is selected. The host then drives the wire high for one clock.
- R8: `cfg_quiet` is read only on the first Stop clock. Changing it at any other time does not change the Stop width or the next mode.
- R9: In continuous mode, the next Start low pulse begins on the clock right after the Stop high clock.
- R10: In quiet mode, the host releases the wire after the Stop high clock. It keeps the wire released for as long as no peripheral pulls it low.
- R11: A `cfg_start_len` value below 3 is treated as 3. The length setting is read when a Start pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sirq_in | input | 1 | Level seen on the shared wire |
| sirq_oe | output | 1 | Host drive enable for the wire |
| sirq_out | output | 1 | Level the host drives when enabled |
| cfg_start_len | input | 3 | Extra host low clocks for a Start pulse (3 to 7) |
| cfg_quiet | input | 1 | Mode request for the next cycle: 1 quiet, 0 continuous |
| irq_vec | output | 16 | Last sampled level of each frame |

## Verification
Two functions can land in the same clock. The host switches into quiet mode at the end of the Stop high clock, and a peripheral can request a new Start on the very first clock after the host releases the wire. The bench provokes this by pulling the wire low on the first released clock after a 2-clock Stop. It passes only if the host counts that clock as the first low clock and then drives exactly L more low clocks. The bench also checks the other overlap, where a continuous-mode Start begins on the clock directly after the Stop high clock, by sampling the wire on that clock.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_LO,
    ST_START_HI,
    ST_DATA,
    ST_STOP_LO,
    ST_STOP_HI
  } sirq_st_e;

  // clocks in one data frame: sample, recovery, turn-around
  localparam int unsigned FRAME_CLKS = 3;

endpackage

// File: rtl/sirq_frame_cnt.sv
module sirq_frame_cnt #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned FRM_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [FRM_W-1:0] frame,
  output logic             smp_en,
  output logic             last
);
  import sirq_host_pkg::*;

  localparam int unsigned PH_W = $clog2(FRAME_CLKS);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(FRAME_CLKS - 1);
  localparam logic [FRM_W-1:0] FR_LAST = FRM_W'(NUM_FRAMES - 1);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [FRM_W-1:0] frame_q, frame_d;

  always_comb begin
    phase_d = phase_q;
    frame_d = frame_q;
    if (!run) begin
      phase_d = '0;
      frame_d = '0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
      frame_d = frame_q + FRM_W'(1);
    end else begin
      phase_d = phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      frame_q <= '0;
    end else begin
      phase_q <= phase_d;
      frame_q <= frame_d;
    end
  end

  assign frame  = frame_q;
  assign smp_en = run && (phase_q == '0);
  assign last   = run && (phase_q == PH_LAST) && (frame_q == FR_LAST);

endmodule

// File: rtl/sirq_vec_cap.sv
module sirq_vec_cap #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned FRM_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_en,
  input  logic [FRM_W-1:0]      frame,
  input  logic                  line_in,
  output logic [NUM_FRAMES-1:0] vec
);

  logic [NUM_FRAMES-1:0] vec_q;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_bit
    logic bit_en, bit_d;
    assign bit_en = smp_en && (frame == FRM_W'(i));
    assign bit_d  = bit_en ? line_in : vec_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q[i] <= 1'b1;
      else        vec_q[i] <= bit_d;
    end
  end

  assign vec = vec_q;

endmodule

// File: rtl/sirq_host_fsm.sv
module sirq_host_fsm #(
  parameter int unsigned LEN_W           = 3,
  parameter int unsigned MIN_HOST_LO     = 3,
  parameter int unsigned STOP_QUIET_CLKS = 2,
  parameter int unsigned STOP_CONT_CLKS  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_in,
  input  logic                        frames_done,
  input  logic [LEN_W-1:0]            cfg_start_len,
  input  logic                        cfg_quiet,
  output sirq_host_pkg::sirq_st_e     st,
  output logic                        quiet,
  output logic                        line_oe,
  output logic                        line_out
);
  import sirq_host_pkg::*;

  localparam int unsigned MAX_LO = (1 << LEN_W);
  localparam int unsigned CNT_W  = $clog2(MAX_LO + STOP_CONT_CLKS + 1);

  sirq_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             quiet_q, quiet_nxt_q, quiet_nxt_d, quiet_en;

  logic [LEN_W-1:0] len_eff;
  logic [CNT_W-1:0] periph_lo_clks, host_lo_clks;

  assign len_eff        = (cfg_start_len < LEN_W'(MIN_HOST_LO)) ? LEN_W'(MIN_HOST_LO)
                                                                 : cfg_start_len;
  assign periph_lo_clks = CNT_W'(len_eff);
  assign host_lo_clks   = CNT_W'(len_eff) + CNT_W'(1);

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    quiet_nxt_d = quiet_nxt_q;
    quiet_en    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!quiet_q) begin
          st_d  = ST_START_LO;
          cnt_d = host_lo_clks;
        end else if (!line_in) begin
          st_d  = ST_START_LO;
          cnt_d = periph_lo_clks;
        end
      end
      ST_START_LO: begin
        if (cnt_q == CNT_W'(1)) st_d  = ST_START_HI;
        else                    cnt_d = cnt_q - CNT_W'(1);
      end
      ST_START_HI: st_d = ST_DATA;
      ST_DATA: begin
        if (frames_done) begin
          st_d        = ST_STOP_LO;
          quiet_nxt_d = cfg_quiet;
          cnt_d       = cfg_quiet ? CNT_W'(STOP_QUIET_CLKS) : CNT_W'(STOP_CONT_CLKS);
        end
      end
      ST_STOP_LO: begin
        if (cnt_q == CNT_W'(1)) st_d  = ST_STOP_HI;
        else                    cnt_d = cnt_q - CNT_W'(1);
      end
      ST_STOP_HI: begin
        quiet_en = 1'b1;
        if (quiet_nxt_q) begin
          st_d = ST_IDLE;
        end else begin
          st_d  = ST_START_LO;
          cnt_d = host_lo_clks;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      quiet_nxt_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      quiet_nxt_q <= quiet_nxt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= 1'b0;
    else if (quiet_en) quiet_q <= quiet_nxt_q;
  end

  assign st       = st_q;
  assign quiet    = quiet_q;
  assign line_oe  = (st_q == ST_START_LO) || (st_q == ST_START_HI) ||
                    (st_q == ST_STOP_LO)  || (st_q == ST_STOP_HI);
  assign line_out = (st_q == ST_START_HI) || (st_q == ST_STOP_HI);

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int unsigned NUM_FRAMES      = 16,
  parameter int unsigned LEN_W           = 3,
  parameter int unsigned MIN_HOST_LO     = 3,
  parameter int unsigned STOP_QUIET_CLKS = 2,
  parameter int unsigned STOP_CONT_CLKS  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sirq_in,
  output logic                  sirq_oe,
  output logic                  sirq_out,
  input  logic [LEN_W-1:0]      cfg_start_len,
  input  logic                  cfg_quiet,
  output logic [NUM_FRAMES-1:0] irq_vec
);
  import sirq_host_pkg::*;

  localparam int unsigned FRM_W = $clog2(NUM_FRAMES);

  // asynchronous assert, synchronous release
  logic rst_s1_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_n   <= 1'b1;
      rst_sync_n <= rst_s1_n;
    end
  end

  sirq_st_e         state;
  logic             quiet_q;
  logic [FRM_W-1:0] frame;
  logic             smp_en, frames_done;

  sirq_host_fsm #(
    .LEN_W          (LEN_W),
    .MIN_HOST_LO    (MIN_HOST_LO),
    .STOP_QUIET_CLKS(STOP_QUIET_CLKS),
    .STOP_CONT_CLKS (STOP_CONT_CLKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .line_in      (sirq_in),
    .frames_done  (frames_done),
    .cfg_start_len(cfg_start_len),
    .cfg_quiet    (cfg_quiet),
    .st           (state),
    .quiet        (quiet_q),
    .line_oe      (sirq_oe),
    .line_out     (sirq_out)
  );

  sirq_frame_cnt #(
    .NUM_FRAMES(NUM_FRAMES),
    .FRM_W     (FRM_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state == ST_DATA),
    .frame (frame),
    .smp_en(smp_en),
    .last  (frames_done)
  );

  sirq_vec_cap #(
    .NUM_FRAMES(NUM_FRAMES),
    .FRM_W     (FRM_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .smp_en (smp_en),
    .frame  (frame),
    .line_in(sirq_in),
    .vec    (irq_vec)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int unsigned NUM_FRAMES  = 16,
  parameter int unsigned MAX_LO_CLKS = 8,
  parameter int unsigned MIN_LO_CLKS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sirq_in,
  input logic                    sirq_oe,
  input logic                    sirq_out,
  input logic [NUM_FRAMES-1:0]   irq_vec,
  input sirq_host_pkg::sirq_st_e st,
  input logic                    quiet_q,
  input logic                    smp_en
);
  import sirq_host_pkg::*;

  logic [3:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lo_run <= '0;
    else if (sirq_oe && !sirq_out) begin
      if (lo_run != 4'hF)            lo_run <= lo_run + 4'd1;
    end else                         lo_run <= '0;
  end

  AST_LOW_RUN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |-> (lo_run >= 4'(MIN_LO_CLKS) && lo_run <= 4'(MAX_LO_CLKS))); // R2

  AST_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |=> !(sirq_oe && sirq_out)); // R4

  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sirq_oe) |-> $past(sirq_out)); // R4

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> !sirq_oe); // R5

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(irq_vec)); // R6

  AST_QUIET_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && quiet_q && sirq_in) |=> !sirq_oe); // R10

endmodule

bind sirq_host sirq_host_chk #(
  .NUM_FRAMES(NUM_FRAMES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sirq_in (sirq_in),
  .sirq_oe (sirq_oe),
  .sirq_out(sirq_out),
  .irq_vec (irq_vec),
  .st      (state),
  .quiet_q (quiet_q),
  .smp_en  (smp_en)
);

// File: tb/sirq_host_tb.sv
module sirq_host_tb;

  logic        clk;
  logic        rst_n;
  logic        periph_low;
  logic [2:0]  cfg_len;
  logic        cfg_quiet;
  logic        sirq_oe, sirq_out;
  logic        sirq_line;
  logic [15:0] irq_vec;

  int n_chk;
  int n_fail;
  bit done;

  assign sirq_line = sirq_oe ? sirq_out : ~periph_low;

  sirq_host u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sirq_in      (sirq_line),
    .sirq_oe      (sirq_oe),
    .sirq_out     (sirq_out),
    .cfg_start_len(cfg_len),
    .cfg_quiet    (cfg_quiet),
    .irq_vec      (irq_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // poll until the host drives low, then count its low clocks
  task automatic meas_host_start(output int lo);
    int w = 0;
    while (!(sirq_oe && !sirq_out) && w < 300) begin
      @(negedge clk);
      w++;
    end
    lo = 0;
    while (sirq_oe && !sirq_out && lo < 20) begin
      lo++;
      @(negedge clk);
    end
  endtask

  // peripheral pulls the released wire low for one clock, host extends
  task automatic meas_periph_start(output int lo);
    chk(!sirq_oe, "R3 wire released before request", sirq_oe, 0);
    periph_low = 1'b1;
    lo = 1;
    @(negedge clk);
    periph_low = 1'b0;
    while (sirq_oe && !sirq_out && lo < 20) begin
      lo++;
      @(negedge clk);
    end
  endtask

  // called at the negedge of the Start high clock
  task automatic bus_frames(input logic [15:0] pat, input int off, input bit flip,
                            input int exp_stop, input logic [15:0] exp_vec);
    int bad = 0;
    int sl  = 0;
    chk(sirq_oe && sirq_out, "R4 one high clock after start", {sirq_oe, sirq_out}, 3);
    for (int d = 0; d < 48; d++) begin
      @(negedge clk);
      if (sirq_oe) bad++;
      periph_low = ((d % 3) == off) && !pat[d / 3];
      if (flip && d == 10) cfg_quiet = 1'b1;
      if (flip && d == 40) cfg_quiet = 1'b0;
    end
    @(negedge clk);
    periph_low = 1'b0;
    chk(bad == 0, "R4 wire released during data frames", bad, 0);
    while (sirq_oe && !sirq_out && sl < 10) begin
      sl++;
      @(negedge clk);
    end
    chk(sl == exp_stop, flip ? "R8 stop width unaffected by mid-cycle change"
                             : "R7 stop low width", sl, exp_stop);
    chk(sirq_oe && sirq_out, "R7 stop high clock", {sirq_oe, sirq_out}, 3);
    chk(irq_vec == exp_vec, (off == 0) ? "R5 captured vector" : "R6 late-phase lows ignored",
        irq_vec, exp_vec);
  endtask

  task automatic expect_cont_start(input int exp_lo, input string req);
    int lo;
    @(negedge clk);
    chk(sirq_oe && !sirq_out, "R9 start right after stop high", {sirq_oe, sirq_out}, 2);
    meas_host_start(lo);
    chk(lo == exp_lo, req, lo, exp_lo);
  endtask

  task automatic t_reset();
    int lo;
    rst_n = 1'b0;
    periph_low = 1'b0;
    cfg_len = 3'd3;
    cfg_quiet = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq_vec == 16'hFFFF, "R1 vector in reset", irq_vec, 16'hFFFF);
    chk(!sirq_oe, "R1 wire released in reset", sirq_oe, 0);
    rst_n = 1'b1;
    meas_host_start(lo);
    chk(lo == 4, "R1 first start host-driven, R2 width", lo, 4);
    chk(irq_vec == 16'hFFFF, "R1 vector after reset", irq_vec, 16'hFFFF);
  endtask

  task automatic t_cont_irq();
    cfg_len = 3'd7;
    bus_frames(16'h7FFD, 0, 1'b0, 3, 16'h7FFD);
    expect_cont_start(8, "R2 start width with setting 7");
  endtask

  task automatic t_short_cfg();
    cfg_len = 3'd1;
    bus_frames(16'hA5C3, 0, 1'b0, 3, 16'hA5C3);
    expect_cont_start(4, "R11 setting 1 treated as 3");
  endtask

  task automatic t_all_low();
    cfg_len = 3'd3;
    bus_frames(16'h0000, 0, 1'b0, 3, 16'h0000);
    expect_cont_start(4, "R2 start width with setting 3");
  endtask

  task automatic t_off_phase();
    bus_frames(16'h0000, 1, 1'b0, 3, 16'hFFFF);
    expect_cont_start(4, "R9 continuous start width");
    bus_frames(16'h0000, 2, 1'b0, 3, 16'hFFFF);
    expect_cont_start(4, "R9 continuous start width");
  endtask

  task automatic t_mode_hold();
    bus_frames(16'hFFDF, 0, 1'b1, 3, 16'hFFDF);
    expect_cont_start(4, "R8 mode stays continuous");
  endtask

  task automatic t_quiet();
    int lo;
    int busy = 0;
    cfg_quiet = 1'b1;
    bus_frames(16'hFFFB, 0, 1'b0, 2, 16'hFFFB);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sirq_oe) busy++;
    end
    chk(busy == 0, "R10 quiet wire stays released", busy, 0);
    cfg_len = 3'd5;
    meas_periph_start(lo);
    chk(lo == 6, "R3 peripheral start total width", lo, 6);
  endtask

  task automatic t_back_to_back();
    int lo;
    cfg_len = 3'd3;
    bus_frames(16'hEFFF, 0, 1'b0, 2, 16'hEFFF);
    @(negedge clk);
    meas_periph_start(lo);
    chk(lo == 4, "R3 request on first released clock", lo, 4);
    cfg_quiet = 1'b0;
    bus_frames(16'hFFFE, 0, 1'b0, 3, 16'hFFFE);
    expect_cont_start(4, "R9 back to continuous");
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    t_reset();
    t_cont_irq();
    t_short_cfg();
    t_all_low();
    t_off_phase();
    t_mode_hold();
    t_quiet();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule